// File: doc/BRIEF.md
# Floppy Controller Reset and Interface-Mode Control

This block is the slice of a floppy disk controller core that decides when the core is held in reset. It also decides how the host's enable bits and the density request reach the rest of the chip. Three sources can hold the core in reset:

- the synchronous active-low hardware reset;
- a sticky reset bit in the host drive-control register, which only a host write can clear;
- a self-clearing reset bit in the host rate register.

A small status code reports which reset source is currently in charge. While the core is in reset, a power-down request is dropped and the polling option returns to its default. The step/head timing word is the one value that keeps its contents across a hardware reset.

A 2-bit interface-mode field selects two things. It chooses whether the drive-control DMA-enable bit gates the interrupt and DMA request paths. It also chooses the polarity of the density-select output. A packed drive status byte combines the drive pins with fixed constant bits.

Top module: `fdc_rstmode_ctl`

## Requirements
- R1: `core_rst` is 1 whenever `rst_n` is low, the control reset bit is set, or the rate reset bit is set; otherwise it is 0.
- R2: A rate-register write with `rate_wr_rst`=1 sets `rate_rst_rd` for exactly RATE_HOLD (default 16) clock cycles. After that it reads 0 without any further host write.
- R3: The control reset bit (`ctl_rst_rd`) keeps its value until a host write with `ctl_wr`=1 loads a new value.
- R4: While `rst_n` is low, the control reset bit is set and the DMA-enable bit is cleared. After `rst_n` returns high, the core stays in reset until the host writes the control reset bit to 0.
- R5: `reset_src` reports the highest-priority active source. The codes are 3 = hardware, 2 = control bit, 1 = rate bit, 0 = none. The control bit outranks the rate bit.
- R6: The timing word loaded through `spec_wr` is unchanged by any reset, including the hardware reset.
- R7: Any reset clears `pd_active` at the next edge, and `pd_req` is ignored during reset. `cmd_ready` is 0 during reset and rises on the second clock edge after all reset sources are released.
- R8: Any reset sets `poll_en` to 1, and `cfg_wr` is ignored during reset. Outside reset, `cfg_wr` loads `poll_en` with the inverse of `cfg_poll_off`.
- R9: With `mode_sel` 0 (and the reserved value 3), `dma_en_eff` and `irq_en_eff` equal the DMA-enable bit, and `dens_out` equals `dens_req`.
- R10: With `mode_sel` 1, the DMA-enable bit has no effect: `dma_en_eff` and `irq_en_eff` are 1, and `dens_out` is the inverse of `dens_req`.
- R11: With `mode_sel` 2, `dma_en_eff` and `irq_en_eff` equal the DMA-enable bit, and `dens_out` is the inverse of `dens_req`.
- R12: `status_byte` has the layout bit7=0, bit6=`wp_in`, bit5=1, bit4=`trk0_in`, bit3=1, bit2=`head_in`, bits1:0=`dsel_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| ctl_wr | input | 1 | Host write strobe for the drive-control register |
| ctl_wr_rst | input | 1 | Written control reset bit (1 = hold core in reset) |
| ctl_wr_dma | input | 1 | Written DMA-enable bit |
| rate_wr | input | 1 | Host write strobe for the rate register |
| rate_wr_rst | input | 1 | Written self-clearing reset bit |
| spec_wr | input | 1 | Load strobe for the timing word |
| spec_data | input | TIMING_W | Timing word value |
| cfg_wr | input | 1 | Load strobe for the polling option |
| cfg_poll_off | input | 1 | 1 = turn drive polling off |
| pd_req | input | 1 | Power-down request |
| mode_sel | input | 2 | Interface mode |
| dens_req | input | 1 | Core's high-density request |
| wp_in | input | 1 | Write-protect pin |
| trk0_in | input | 1 | Track-zero pin |
| head_in | input | 1 | Head select |
| dsel_in | input | 2 | Drive select |
| core_rst | output | 1 | Core reset, active high |
| ctl_rst_rd | output | 1 | Readback of control reset bit |
| rate_rst_rd | output | 1 | Readback of rate reset bit |
| reset_src | output | 2 | Active reset source code |
| dma_en_eff | output | 1 | Effective DMA request enable |
| irq_en_eff | output | 1 | Effective interrupt enable |
| dens_out | output | 1 | Density select with mode polarity |
| pd_active | output | 1 | Core is powered down |
| poll_en | output | 1 | Drive polling enabled |
| cmd_ready | output | 1 | Core idle, waiting in command phase |
| timing_q | output | TIMING_W | Retained timing word |
| status_byte | output | 8 | Packed drive status |

## Verification
The bench counts every cycle of the self-clearing reset. A counter that is off by one, or that never expires, shows up as a readback high for 15, 17 or unbounded cycles.

It overlaps the two software resets and releases them in turn. A design with inverted precedence reports the rate source while the control bit is set. A design that lets the expiring rate bit release the core would drop `core_rst` too early.

A hardware reset pulse follows a timing-word load. A design that resets that word loses it. A design that forgets to set the sticky bit leaves reset as soon as `rst_n` rises.

Every combination of mode, enable bit and density request is swept, which catches a mode that reads the enable bit when it should ignore it or drives the wrong polarity. All 32 status pin combinations are also swept to catch swapped or misplaced fields.

// File: rtl/fdc_rm_pkg.sv
// Shared encodings for the floppy reset/mode control slice.
package fdc_rm_pkg;
    // Interface mode field values
    typedef enum logic [1:0] {
        MODE_STD     = 2'd0,
        MODE_ALWAYS  = 2'd1,
        MODE_GATED_L = 2'd2,
        MODE_RSVD    = 2'd3
    } ifc_mode_e;

    // Reset source code, higher value wins
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_RATE = 2'd1,
        SRC_CTL  = 2'd2,
        SRC_HW   = 2'd3
    } rst_src_e;

    // Packed drive status layout
    typedef struct packed {
        logic       zero7;
        logic       wp;
        logic       one5;
        logic       trk0;
        logic       one3;
        logic       head;
        logic [1:0] dsel;
    } drv_status_t;
endpackage

// File: rtl/fdc_rm_reset_ctl.sv
// Reset arbitration. Holds the sticky control reset bit and the DMA-enable bit,
// and the self-clearing rate reset counter. Combines them with the hardware
// reset into the core reset and a prioritised source code.
// Assumes: rst_n is synchronous, active low; host strobes are one-cycle pulses.
module fdc_rm_reset_ctl
    import fdc_rm_pkg::*;
#(
    parameter int RATE_HOLD = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       ctl_wr_rst,
    input  logic       ctl_wr_dma,
    input  logic       rate_wr,
    input  logic       rate_wr_rst,
    output logic       ctl_rst_q,
    output logic       ctl_dma_q,
    output logic       rate_rst_q,
    output logic       core_rst,
    output rst_src_e   src
);
    localparam int CNT_W = $clog2(RATE_HOLD + 1);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(RATE_HOLD);

    logic [CNT_W-1:0] rate_cnt;

    // Control register: hardware reset sets the reset bit and clears DMA enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_rst_q <= 1'b1;
            ctl_dma_q <= 1'b0;
        end else if (ctl_wr) begin
            ctl_rst_q <= ctl_wr_rst;
            ctl_dma_q <= ctl_wr_dma;
        end
    end

    // Rate reset counter: loads on a write of the reset bit, then counts out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_cnt <= '0;
        end else if (rate_wr && rate_wr_rst) begin
            rate_cnt <= HOLD_V;
        end else if (rate_cnt != '0) begin
            rate_cnt <= rate_cnt - 1'b1;
        end
    end

    assign rate_rst_q = (rate_cnt != '0);

    // Core reset and priority encoding of the active source
    always_comb begin
        core_rst = !rst_n || ctl_rst_q || rate_rst_q;
        if (!rst_n)          src = SRC_HW;
        else if (ctl_rst_q)  src = SRC_CTL;
        else if (rate_rst_q) src = SRC_RATE;
        else                 src = SRC_NONE;
    end
endmodule

// File: rtl/fdc_rm_core_state.sv
// Core state touched by reset: power-down, polling option, command-phase ready
// and the timing word that survives every reset.
// Assumes: core_rst already includes the hardware reset.
module fdc_rm_core_state #(
    parameter int TIMING_W = 8
) (
    input  logic                clk,
    input  logic                core_rst,
    input  logic                pd_req,
    input  logic                cfg_wr,
    input  logic                cfg_poll_off,
    input  logic                spec_wr,
    input  logic [TIMING_W-1:0] spec_data,
    output logic                pd_active,
    output logic                poll_en,
    output logic                cmd_ready,
    output logic [TIMING_W-1:0] timing_q
);
    // Power-down: any reset wakes the core; requests ignored during reset
    always_ff @(posedge clk) begin
        if (core_rst)    pd_active <= 1'b0;
        else if (pd_req) pd_active <= 1'b1;
    end

    // Polling option: reset re-enables polling
    always_ff @(posedge clk) begin
        if (core_rst)    poll_en <= 1'b1;
        else if (cfg_wr) poll_en <= !cfg_poll_off;
    end

    // Command-phase ready follows reset release by one register
    always_ff @(posedge clk) begin
        cmd_ready <= !core_rst;
    end

    // Timing word: intentionally without reset so it survives all sources
    always_ff @(posedge clk) begin
        if (spec_wr) timing_q <= spec_data;
    end
endmodule

// File: rtl/fdc_rm_mode_map.sv
// Interface-mode decode: effective DMA/interrupt enables and the
// density-select polarity. Purely combinational.
module fdc_rm_mode_map
    import fdc_rm_pkg::*;
(
    input  logic [1:0] mode_sel,
    input  logic       ctl_dma_q,
    input  logic       dens_req,
    output logic       dma_en_eff,
    output logic       irq_en_eff,
    output logic       dens_out
);
    logic force_en;
    logic dens_low;

    // Decode the mode into an enable override and a polarity select
    always_comb begin
        unique case (ifc_mode_e'(mode_sel))
            MODE_ALWAYS:  begin force_en = 1'b1; dens_low = 1'b1; end
            MODE_GATED_L: begin force_en = 1'b0; dens_low = 1'b1; end
            default:      begin force_en = 1'b0; dens_low = 1'b0; end
        endcase
    end

    // Apply the override and polarity
    always_comb begin
        dma_en_eff = force_en || ctl_dma_q;
        irq_en_eff = force_en || ctl_dma_q;
        dens_out   = dens_req ^ dens_low;
    end
endmodule

// File: rtl/fdc_rm_status.sv
// Packs the drive pins into the status byte with its constant bits.
module fdc_rm_status
    import fdc_rm_pkg::*;
(
    input  logic       wp_in,
    input  logic       trk0_in,
    input  logic       head_in,
    input  logic [1:0] dsel_in,
    output logic [7:0] status_byte
);
    drv_status_t st;

    // Fill the packed layout
    always_comb begin
        st.zero7 = 1'b0;
        st.wp    = wp_in;
        st.one5  = 1'b1;
        st.trk0  = trk0_in;
        st.one3  = 1'b1;
        st.head  = head_in;
        st.dsel  = dsel_in;
        status_byte = st;
    end
endmodule

// File: rtl/fdc_rstmode_ctl.sv
// Top of the floppy reset/mode slice. Wires reset arbitration, core state,
// mode decode and status packing together.
// Assumes: single clock domain, synchronous active-low hardware reset.
module fdc_rstmode_ctl
    import fdc_rm_pkg::*;
#(
    parameter int RATE_HOLD = 16,
    parameter int TIMING_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic                ctl_wr_rst,
    input  logic                ctl_wr_dma,
    input  logic                rate_wr,
    input  logic                rate_wr_rst,
    input  logic                spec_wr,
    input  logic [TIMING_W-1:0] spec_data,
    input  logic                cfg_wr,
    input  logic                cfg_poll_off,
    input  logic                pd_req,
    input  logic [1:0]          mode_sel,
    input  logic                dens_req,
    input  logic                wp_in,
    input  logic                trk0_in,
    input  logic                head_in,
    input  logic [1:0]          dsel_in,
    output logic                core_rst,
    output logic                ctl_rst_rd,
    output logic                rate_rst_rd,
    output logic [1:0]          reset_src,
    output logic                dma_en_eff,
    output logic                irq_en_eff,
    output logic                dens_out,
    output logic                pd_active,
    output logic                poll_en,
    output logic                cmd_ready,
    output logic [TIMING_W-1:0] timing_q,
    output logic [7:0]          status_byte
);
    logic     ctl_dma_q;
    rst_src_e src;

    fdc_rm_reset_ctl #(.RATE_HOLD(RATE_HOLD)) u_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_wr_rst (ctl_wr_rst),
        .ctl_wr_dma (ctl_wr_dma),
        .rate_wr    (rate_wr),
        .rate_wr_rst(rate_wr_rst),
        .ctl_rst_q  (ctl_rst_rd),
        .ctl_dma_q  (ctl_dma_q),
        .rate_rst_q (rate_rst_rd),
        .core_rst   (core_rst),
        .src        (src)
    );

    assign reset_src = src;

    fdc_rm_core_state #(.TIMING_W(TIMING_W)) u_state (
        .clk         (clk),
        .core_rst    (core_rst),
        .pd_req      (pd_req),
        .cfg_wr      (cfg_wr),
        .cfg_poll_off(cfg_poll_off),
        .spec_wr     (spec_wr),
        .spec_data   (spec_data),
        .pd_active   (pd_active),
        .poll_en     (poll_en),
        .cmd_ready   (cmd_ready),
        .timing_q    (timing_q)
    );

    fdc_rm_mode_map u_mode (
        .mode_sel  (mode_sel),
        .ctl_dma_q (ctl_dma_q),
        .dens_req  (dens_req),
        .dma_en_eff(dma_en_eff),
        .irq_en_eff(irq_en_eff),
        .dens_out  (dens_out)
    );

    fdc_rm_status u_stat (
        .wp_in      (wp_in),
        .trk0_in    (trk0_in),
        .head_in    (head_in),
        .dsel_in    (dsel_in),
        .status_byte(status_byte)
    );
endmodule

// File: rtl/fdc_rstmode_chk.sv
// Property checker for fdc_rstmode_ctl, attached by bind below.
// Bounds the self-clearing reset with a counter instead of a long $past.
module fdc_rstmode_chk #(
    parameter int RATE_HOLD = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rate_wr,
    input logic       rate_wr_rst,
    input logic       core_rst,
    input logic       ctl_rst_rd,
    input logic       rate_rst_rd,
    input logic [1:0] reset_src,
    input logic       pd_active,
    input logic [1:0] mode_sel,
    input logic       dma_en_eff,
    input logic       irq_en_eff,
    input logic [7:0] status_byte
);
    localparam int SW = $clog2(RATE_HOLD + 2) + 1;
    localparam logic [SW-1:0] SAT = SW'(RATE_HOLD + 1);

    logic [SW-1:0] since_wr;

    // Cycles since the last rate reset write, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                       since_wr <= SAT;
        else if (rate_wr && rate_wr_rst)  since_wr <= SW'(1);
        else if (since_wr < SAT)          since_wr <= since_wr + 1'b1;
    end

    a_r1_ctl_holds_core: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rst_rd || rate_rst_rd) |-> core_rst);
    a_r2_rate_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        rate_rst_rd |-> (since_wr <= SW'(RATE_HOLD)));
    a_r4_sticky_after_hw: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ctl_rst_rd);
    a_r5_ctl_outranks_rate: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst_rd |-> (reset_src == 2'd2));
    a_r7_reset_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> !pd_active);
    a_r10_mode1_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd1) |-> (dma_en_eff && irq_en_eff));
    a_r12_const_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_byte[7] && status_byte[5] && status_byte[3]));
endmodule

bind fdc_rstmode_ctl fdc_rstmode_chk #(.RATE_HOLD(RATE_HOLD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_wr    (rate_wr),
    .rate_wr_rst(rate_wr_rst),
    .core_rst   (core_rst),
    .ctl_rst_rd (ctl_rst_rd),
    .rate_rst_rd(rate_rst_rd),
    .reset_src  (reset_src),
    .pd_active  (pd_active),
    .mode_sel   (mode_sel),
    .dma_en_eff (dma_en_eff),
    .irq_en_eff (irq_en_eff),
    .status_byte(status_byte)
);

// File: tb/sim_fdc_rstmode_ctl.sv
`timescale 1ns/1ps
module sim_fdc_rstmode_ctl;
    localparam int HOLD = 16;
    localparam int TW   = 8;

    logic clk = 1'b0;
    logic rst_n, ctl_wr, ctl_wr_rst, ctl_wr_dma, rate_wr, rate_wr_rst;
    logic spec_wr, cfg_wr, cfg_poll_off, pd_req, dens_req;
    logic wp_in, trk0_in, head_in;
    logic [1:0] dsel_in, mode_sel;
    logic [TW-1:0] spec_data;
    logic core_rst, ctl_rst_rd, rate_rst_rd, dma_en_eff, irq_en_eff, dens_out;
    logic pd_active, poll_en, cmd_ready;
    logic [1:0] reset_src;
    logic [TW-1:0] timing_q;
    logic [7:0] status_byte;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fdc_rstmode_ctl #(.RATE_HOLD(HOLD), .TIMING_W(TW)) u0 (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic ctl_write(input logic r, input logic d);
        ctl_wr = 1'b1; ctl_wr_rst = r; ctl_wr_dma = d;
        tick();
        ctl_wr = 1'b0;
    endtask

    initial begin
        #(4ns * 200000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 0; ctl_wr = 0; ctl_wr_rst = 0; ctl_wr_dma = 0; rate_wr = 0;
        rate_wr_rst = 0; spec_wr = 0; spec_data = '0; cfg_wr = 0;
        cfg_poll_off = 0; pd_req = 0; mode_sel = 0; dens_req = 0;
        wp_in = 0; trk0_in = 0; head_in = 0; dsel_in = 0;
        repeat (4) tick();
        check("R1 hw core_rst", core_rst, 1);
        check("R5 hw src", reset_src, 3);
        check("R4 ctl bit set by hw", ctl_rst_rd, 1);
        check("R7 cmd_ready low", cmd_ready, 0);
        check("R8 poll default", poll_en, 1);

        rst_n = 1; tick();
        check("R4 held after hw release", core_rst, 1);
        check("R5 ctl src", reset_src, 2);
        repeat (5) tick();
        check("R3 ctl bit sticky", ctl_rst_rd, 1);
        pd_req = 1; cfg_wr = 1; cfg_poll_off = 1; tick();
        pd_req = 0; cfg_wr = 0;
        check("R7 pd ignored in reset", pd_active, 0);
        check("R8 cfg ignored in reset", poll_en, 1);

        ctl_write(1'b0, 1'b0);
        check("R1 released", core_rst, 0);
        check("R5 none src", reset_src, 0);
        check("R7 cmd_ready one edge", cmd_ready, 0);
        tick();
        check("R7 cmd_ready second edge", cmd_ready, 1);

        spec_wr = 1; spec_data = 8'hA5; pd_req = 1; cfg_wr = 1; cfg_poll_off = 1;
        tick();
        spec_wr = 0; pd_req = 0; cfg_wr = 0;
        check("R6 timing loaded", timing_q, 8'hA5);
        check("R7 pd set", pd_active, 1);
        check("R8 poll off", poll_en, 0);

        // Self-clearing reset: exactly HOLD cycles high
        rate_wr = 1; rate_wr_rst = 1; tick(); rate_wr = 0;
        for (int i = 0; i < HOLD; i++) begin
            check("R2 rate bit high", rate_rst_rd, 1);
            check("R1 rate core_rst", core_rst, 1);
            check("R5 rate src", reset_src, 1);
            tick();
        end
        check("R2 rate bit cleared", rate_rst_rd, 0);
        check("R1 rate released", core_rst, 0);
        check("R7 pd cleared by reset", pd_active, 0);
        check("R8 poll re-enabled", poll_en, 1);
        check("R6 timing kept", timing_q, 8'hA5);

        // Overlap: control outranks rate, release in turn
        ctl_write(1'b1, 1'b0);
        rate_wr = 1; rate_wr_rst = 1; tick(); rate_wr = 0;
        check("R5 ctl over rate", reset_src, 2);
        check("R2 both readbacks", rate_rst_rd, 1);
        repeat (HOLD + 2) tick();
        check("R2 rate cleared under ctl", rate_rst_rd, 0);
        check("R1 ctl still holds", core_rst, 1);
        check("R3 ctl still set", ctl_rst_rd, 1);
        ctl_write(1'b0, 1'b0);
        rate_wr = 1; rate_wr_rst = 1; tick(); rate_wr = 0;
        ctl_write(1'b1, 1'b0);
        ctl_write(1'b0, 1'b0);
        check("R1 rate keeps core after ctl clear", core_rst, 1);
        check("R5 rate src after ctl clear", reset_src, 1);
        repeat (HOLD) tick();
        check("R1 all released", core_rst, 0);

        // Hardware reset keeps the timing word
        ctl_write(1'b0, 1'b1);
        rst_n = 0; repeat (2) tick(); rst_n = 1; tick();
        check("R6 timing after hw", timing_q, 8'hA5);
        check("R4 dma cleared by hw", dma_en_eff, 0);
        check("R4 sticky after hw", core_rst, 1);
        ctl_write(1'b0, 1'b0);

        // Mode sweep
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int h = 0; h < 2; h++) begin
                    int g, ds;
                    ctl_write(1'b0, d[0]);
                    mode_sel = m[1:0]; dens_req = h[0];
                    #1;
                    g  = (m == 1) ? 1 : d;
                    ds = (m == 0 || m == 3) ? h : 1 - h;
                    if (m == 1) begin
                        check("R10 dma", dma_en_eff, g);
                        check("R10 irq", irq_en_eff, g);
                        check("R10 dens", dens_out, ds);
                    end else if (m == 2) begin
                        check("R11 dma", dma_en_eff, g);
                        check("R11 irq", irq_en_eff, g);
                        check("R11 dens", dens_out, ds);
                    end else begin
                        check("R9 dma", dma_en_eff, g);
                        check("R9 irq", irq_en_eff, g);
                        check("R9 dens", dens_out, ds);
                    end
                end
            end
        end

        // Status byte sweep
        for (int p = 0; p < 32; p++) begin
            tick();
            wp_in = p[4]; trk0_in = p[3]; head_in = p[2]; dsel_in = p[1:0];
            #1;
            check("R12 status", status_byte,
                  (p[4] * 64) + 32 + (p[3] * 16) + 8 + (p[2] * 4) + (p % 4));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule